// File: doc/BRIEF.md
# Predicate Register File with Complementary Compare Writes

This block holds the one-bit predicates of a predicated execution pipeline. When a branch has been replaced by predication, instructions from both arms issue and execute before the condition is known, each tagged with the index of the predicate that guards it. A compare resolves the condition and stores the outcome as a complementary pair in one operation: one named register becomes TRUE and a second named register becomes FALSE. The compare arithmetic happens outside this block. The caller presents the resolved outcome as the index that receives TRUE and the index that receives FALSE.

At the commit stage each instruction's guard is looked up. The instruction retires when its predicate is TRUE and is squashed otherwise. A compare that writes a register in the same cycle that a commit reads it is forwarded, so the commit sees the new value without waiting a cycle. Register 0 always reads TRUE, so unpredicated instructions name it. The 63 writable registers can carry many disjoint pairs at the same time, which supports deeply nested predicated regions.

Top module: `pred_file`

## Requirements
- R1: The file holds 64 one-bit registers with indices 0 to 63. Each register is written and read independently of all the others.
- R2: Register 0 always reads TRUE. A compare that names index 0 as either target leaves it TRUE.
- R3: When `cmp_valid_i[p]` is 1, the register at `cmp_true_idx_i[p]` reads TRUE from the next cycle on, and the register at `cmp_false_idx_i[p]` reads FALSE. When `cmp_valid_i[p]` is 0, the indices on that port have no effect.
- R4: When both targets of one compare name the same register, that register becomes TRUE.
- R5: A register that no valid compare names keeps its value.
- R6: When two write ports name the same register in the same cycle, port 1 (the higher-numbered port) determines the value.
- R7: A valid commit port asserts `retire_o` when its predicate is TRUE and `squash_o` when it is FALSE, never both at once. An invalid commit port asserts neither. Both outputs are combinational in the same cycle.
- R8: A commit that reads a register in the same cycle a compare writes it sees the value being written.
- R9: After reset every register except register 0 reads FALSE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_valid_i | input | 2 | Compare write valid, one bit per write port |
| cmp_true_idx_i | input | 2x6 | Index that receives TRUE, per write port |
| cmp_false_idx_i | input | 2x6 | Index that receives FALSE, per write port |
| cm_valid_i | input | 3 | Commit lookup valid, one bit per commit port |
| cm_idx_i | input | 3x6 | Guarding predicate index, per commit port |
| retire_o | output | 3 | Instruction may retire, per commit port |
| squash_o | output | 3 | Instruction result is discarded, per commit port |

## Verification
The main function is exercised with four kinds of input pattern:
- A single compare to two distinct registers, read back one cycle later. This shows whether the complementary pair lands correctly.
- A compare read in the same cycle it writes. This separates the forwarded value from the stale stored value.
- A compare whose two targets coincide, and two ports that collide on the same pair in opposite directions. These expose the wrong priority within a port and the wrong priority between ports.
- A sweep that fills every writable register with alternating pairs and reads all 64 back. This catches crossed or aliased index decoding.

Further patterns cover writes aimed at register 0, compares with valid low, and idle commit ports.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int unsigned PRED_NUM  = 64;
  localparam int unsigned PRED_WR_N = 2;
  localparam int unsigned PRED_RD_N = 3;
endpackage

// File: rtl/pred_wr_decode.sv
module pred_wr_decode #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             valid_i,
  input  logic [IDX_W-1:0] true_idx_i,
  input  logic [IDX_W-1:0] false_idx_i,
  output logic [N-1:0]     en_o,
  output logic [N-1:0]     val_o
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] t_hot, f_hot;
  assign t_hot = ONE << true_idx_i;
  assign f_hot = ONE << false_idx_i;

  // value carries only the TRUE bit, so a shared target resolves to TRUE
  assign en_o  = valid_i ? (t_hot | f_hot) : '0;
  assign val_o = valid_i ? t_hot : '0;
endmodule

// File: rtl/pred_store.sv
module pred_store #(
  parameter int unsigned N   = 64,
  parameter int unsigned NWR = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NWR-1:0][N-1:0]   en_i,
  input  logic [NWR-1:0][N-1:0]   val_i,
  output logic [N-1:0]            q_o,
  output logic [N-1:0]            d_o
);
  localparam logic [N-1:0] RST_VAL = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] any_en;

  always_comb begin
    d_o    = q_o;
    any_en = '0;
    for (int p = 0; p < NWR; p++) begin
      d_o    = (d_o & ~en_i[p]) | (val_i[p] & en_i[p]);
      any_en = any_en | en_i[p];
    end
    d_o[0] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= d_o;
  end

  for (genvar k = 1; k < N; k++) begin : g_hold
    AST_UNTOUCHED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !any_en[k] |=> $stable(q_o[k])) else $error("untouched predicate changed"); // R5
  end
endmodule

// File: rtl/pred_read_port.sv
module pred_read_port #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [N-1:0]     fwd_i,
  output logic             retire_o,
  output logic             squash_o
);
  logic pred;
  assign pred     = fwd_i[idx_i];
  assign retire_o = valid_i & pred;
  assign squash_o = valid_i & ~pred;

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $countones({retire_o, squash_o}) == 1) else $error("commit outcome not unique"); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !retire_o && !squash_o) else $error("idle commit port active"); // R7
  AST_REG0_RETIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && idx_i == '0 |-> retire_o) else $error("register 0 squashed"); // R2
endmodule

// File: rtl/pred_file.sv
module pred_file
  import pred_pkg::*;
#(
  parameter int unsigned NUM_PREDS = PRED_NUM,
  parameter int unsigned NUM_WR    = PRED_WR_N,
  parameter int unsigned NUM_RD    = PRED_RD_N,
  localparam int unsigned IDX_W    = $clog2(NUM_PREDS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_WR-1:0]            cmp_valid_i,
  input  logic [NUM_WR-1:0][IDX_W-1:0] cmp_true_idx_i,
  input  logic [NUM_WR-1:0][IDX_W-1:0] cmp_false_idx_i,
  input  logic [NUM_RD-1:0]            cm_valid_i,
  input  logic [NUM_RD-1:0][IDX_W-1:0] cm_idx_i,
  output logic [NUM_RD-1:0]            retire_o,
  output logic [NUM_RD-1:0]            squash_o
);
  logic [NUM_WR-1:0][NUM_PREDS-1:0] wr_en, wr_val;
  logic [NUM_PREDS-1:0]             pred_q, pred_d;

  for (genvar p = 0; p < NUM_WR; p++) begin : g_wr
    pred_wr_decode #(.N(NUM_PREDS), .IDX_W(IDX_W)) u_dec (
      .valid_i    (cmp_valid_i[p]),
      .true_idx_i (cmp_true_idx_i[p]),
      .false_idx_i(cmp_false_idx_i[p]),
      .en_o       (wr_en[p]),
      .val_o      (wr_val[p])
    );
  end

  pred_store #(.N(NUM_PREDS), .NWR(NUM_WR)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (wr_en),
    .val_i (wr_val),
    .q_o   (pred_q),
    .d_o   (pred_d)
  );

  // commit reads the post-write vector: same-cycle compares are forwarded
  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    pred_read_port #(.N(NUM_PREDS), .IDX_W(IDX_W)) u_rd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (cm_valid_i[r]),
      .idx_i   (cm_idx_i[r]),
      .fwd_i   (pred_d),
      .retire_o(retire_o[r]),
      .squash_o(squash_o[r])
    );
  end

  AST_LAST_PORT_TRUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i[NUM_WR-1] |=> pred_q[$past(cmp_true_idx_i[NUM_WR-1])])
    else $error("true target not set"); // R3
  AST_LAST_PORT_FALSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i[NUM_WR-1] && cmp_true_idx_i[NUM_WR-1] != cmp_false_idx_i[NUM_WR-1]
      && cmp_false_idx_i[NUM_WR-1] != '0
    |=> !pred_q[$past(cmp_false_idx_i[NUM_WR-1])]) else $error("false target not cleared"); // R6
  AST_REG0_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_q[0]) else $error("register 0 lost TRUE"); // R2
endmodule

// File: tb/pred_file_test.sv
module pred_file_test;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_ni;
  logic [1:0]      cmp_valid;
  logic [1:0][5:0] cmp_t, cmp_f;
  logic [2:0]      cm_valid;
  logic [2:0][5:0] cm_idx;
  logic [2:0]      retire, squash;

  int checks = 0;
  int errors = 0;
  bit exp_q [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_file uut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .cmp_valid_i    (cmp_valid),
    .cmp_true_idx_i (cmp_t),
    .cmp_false_idx_i(cmp_f),
    .cm_valid_i     (cm_valid),
    .cm_idx_i       (cm_idx),
    .retire_o       (retire),
    .squash_o       (squash)
  );

  task automatic clr_in();
    cmp_valid = '0; cmp_t = '0; cmp_f = '0;
    cm_valid = '0; cm_idx = '0;
  endtask

  task automatic set_cmp(int p, int t, int f);
    cmp_valid[p] = 1'b1; cmp_t[p] = 6'(t); cmp_f[p] = 6'(f);
  endtask

  // applies pending compares to the model in port order, then clocks
  task automatic tick();
    for (int p = 0; p < 2; p++)
      if (cmp_valid[p]) begin
        if (cmp_f[p] != 0) exp_q[cmp_f[p]] = 1'b0;
        if (cmp_t[p] != 0) exp_q[cmp_t[p]] = 1'b1;
      end
    @(posedge clk);
    @(negedge clk);
    clr_in();
  endtask

  task automatic chk(int p, int idx, bit e, string req);
    cm_valid[p] = 1'b1; cm_idx[p] = 6'(idx);
    #1;
    checks++;
    if (retire[p] !== e || squash[p] !== !e) begin
      errors++;
      $display("FAIL %s port %0d idx %0d: retire=%b squash=%b expected retire=%b squash=%b",
               req, p, idx, retire[p], squash[p], e, !e);
    end
    cm_valid[p] = 1'b0;
  endtask

  task automatic t_reset();  // R9
    for (int i = 0; i < 64; i++) chk(i % 3, i, i == 0, "R9");
  endtask

  task automatic t_pair();   // R3
    set_cmp(0, 5, 9); tick();
    chk(0, 5, 1'b1, "R3"); chk(1, 9, 1'b0, "R3");
    cmp_t[0] = 6'd9; cmp_f[0] = 6'd5; tick();  // valid low: ignored
    chk(2, 5, 1'b1, "R3"); chk(0, 9, 1'b0, "R3");
  endtask

  task automatic t_forward(); // R8
    set_cmp(0, 9, 5);
    chk(1, 9, 1'b1, "R8"); chk(2, 5, 1'b0, "R8");
    tick();
    chk(0, 9, 1'b1, "R8"); chk(0, 5, 1'b0, "R8");
  endtask

  task automatic t_same();   // R4
    set_cmp(1, 12, 12); chk(0, 12, 1'b1, "R4");
    tick();
    chk(2, 12, 1'b1, "R4");
  endtask

  task automatic t_reg0();   // R2
    set_cmp(0, 3, 0); set_cmp(1, 0, 0); chk(1, 0, 1'b1, "R2");
    tick();
    chk(0, 0, 1'b1, "R2"); chk(2, 3, 1'b1, "R2");
  endtask

  task automatic t_conflict(); // R6
    set_cmp(0, 20, 21); set_cmp(1, 21, 20);
    chk(2, 21, 1'b1, "R6");
    tick();
    chk(0, 21, 1'b1, "R6"); chk(1, 20, 1'b0, "R6");
  endtask

  task automatic t_sweep();  // R1 R5
    for (int k = 1; k < 32; k++) begin
      if (k % 2 == 1) set_cmp(0, 2*k, 2*k+1); else set_cmp(0, 2*k+1, 2*k);
      tick();
    end
    set_cmp(1, 1, 0); tick();
    for (int i = 0; i < 64; i++) chk(i % 3, i, exp_q[i], "R1");
    chk(0, 5, exp_q[5], "R5");
  endtask

  task automatic t_idle();   // R7
    cm_valid = '0; cm_idx = '{6'd0, 6'd1, 6'd2};
    #1;
    for (int p = 0; p < 3; p++) begin
      checks++;
      if (retire[p] !== 1'b0 || squash[p] !== 1'b0) begin
        errors++;
        $display("FAIL R7 idle port %0d: retire=%b squash=%b expected 0 0", p, retire[p], squash[p]);
      end
    end
    chk(2, 2, exp_q[2], "R7");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) exp_q[i] = (i == 0);
    clr_in();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_pair();
    t_forward();
    t_same();
    t_reg0();
    t_conflict();
    t_sweep();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule